// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Control

This block is a computer-operating-properly watchdog. A down counter runs off one of three clock-enable strobes and raises a one-cycle reset request when it runs out. A 3-bit rate code sets the length of the timeout, and code 000 turns the watchdog off. The control byte is loaded at reset time through a load port and can also be changed by register writes.

The write rules depend on a mode input. In normal mode the window bit and the rate code take a single accepted write per reset. In special mode they can be rewritten freely. In both modes, a mask bit in the written data blocks changes to the window bit and the rate code. The stop-in-debug flag can only be set in normal mode.

Some events restart the timeout: certain writes, a change of clock source, and loss of oscillator-up status while the oscillator is the selected source. In stop modes the counter either keeps counting or holds its value, depending on the clock selection.

Top module: `wdog_ctl`

## Requirements
- R1: After reset `rd_data` reads 0x00 and `reset_req` is low. The read layout is: bit 7 window, bit 6 stop-in-debug, bit 5 mask (always reads 0), bits 4:3 zero, bits 2:0 rate code.
- R2: Rate codes 1..7 select a period P of 2^(E−EXP_REDUCE) cycles, with E = 14, 16, 18, 20, 22, 23, 24. Suppose the selected enable is held high. The rising edge that accepts a restarting event is edge 0. `reset_req` is then high after edge P+1.
- R3: The request lasts one cycle. The counter then reloads, so the next request follows P cycles later.
- R4: With rate code 000 no request is ever raised.
- R5: A `load_en` pulse sets the window bit and the rate code from `load_data[7]` and `load_data[2:0]`. A non-zero code starts the timeout.
- R6: In normal mode only the first write with mask (`wr_data[5]`) at 0 after reset may change the window bit or the rate code. Later writes leave both unchanged.
- R7: A write with `wr_data[5]`=1 changes neither the window bit nor the rate code. In normal mode it does not use up the single write.
- R8: In normal mode a write of rate 000 or window 0 leaves the stored value as it is, but still uses up the single write.
- R9: In normal mode the stop-in-debug bit (bit 6) can only go from 0 to 1, and that rise restarts the timeout. In special mode the bit follows every write.
- R10: In special mode, writes with mask 0 set the window bit and the rate code directly. Every write restarts the timeout, including masked ones.
- R11: `clk_sel` picks the count enable: 00 `irc_en`, 01 `osc_en`, 1x `aux_en`. Any change of `clk_sel` restarts the timeout. So does a fall of `osc_up` while `clk_sel`=01.
- R12: When `stop_mode` is 1 the counter holds its value, except in two cases where it keeps counting: `clk_sel[1]`=1, or `pseudo_stop`=1 with `clk_sel`=01 and `osc_en_stop`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | 1 = special mode, 0 = normal mode |
| stop_mode | input | 1 | Device is in a stop mode |
| pseudo_stop | input | 1 | The stop mode is the pseudo variant |
| osc_en_stop | input | 1 | Oscillator kept enabled during stop |
| osc_up | input | 1 | Oscillator-up status |
| clk_sel | input | 2 | Count-source select |
| aux_en | input | 1 | Auxiliary clock enable strobe |
| irc_en | input | 1 | Internal RC clock enable strobe |
| osc_en | input | 1 | Oscillator clock enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| load_en | input | 1 | Reset-time load strobe |
| load_data | input | 8 | Reset-time load data |
| rd_data | output | 8 | Control register read value |
| reset_req | output | 1 | One-cycle timeout reset request |

## Verification
The bench builds the block with EXP_REDUCE = 10. This shrinks the shortest period to 16 cycles and code 2 to 64 cycles. With those lengths the exact request edge, the repeat interval and each restart source can be measured to the cycle, well within the run length. At the default value the same cases would need 16k-cycle waits or more. The frozen-in-stop and disabled cases are checked over windows several times longer than the active period.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int REG_W    = 8;
   localparam int RATE_W   = 3;
   localparam int BIT_WIN  = 7;
   localparam int BIT_SBD  = 6;
   localparam int BIT_MASK = 5;
   localparam int MAX_EXP  = 24;

   // exponent of the timeout period for each rate code (code 0 unused)
   function automatic int rate_exp(input logic [RATE_W-1:0] code);
      case (code)
         3'd1:    return 14;
         3'd2:    return 16;
         3'd3:    return 18;
         3'd4:    return 20;
         3'd5:    return 22;
         3'd6:    return 23;
         3'd7:    return 24;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
   import wdog_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_mode,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              load_en,
   input  logic [REG_W-1:0]  load_data,
   input  logic [1:0]        clk_sel,
   input  logic              osc_up,
   output logic              win_q,
   output logic              sbd_q,
   output logic [RATE_W-1:0] rate_q,
   output logic              restart_q
);
   logic              once_q, osc_q;
   logic [1:0]        sel_q;
   logic              win_n, sbd_n, once_n, rs_n;
   logic [RATE_W-1:0] rate_n;
   logic              unmasked;

   assign unmasked = !wr_data[BIT_MASK];

   always_comb begin
      win_n  = win_q;
      sbd_n  = sbd_q;
      rate_n = rate_q;
      once_n = once_q;
      rs_n   = 1'b0;
      if (wr_en) begin
         if (special_mode) begin
            rs_n  = 1'b1;
            sbd_n = wr_data[BIT_SBD];
            if (unmasked) begin
               win_n  = wr_data[BIT_WIN];
               rate_n = wr_data[RATE_W-1:0];
            end
         end else begin
            if (wr_data[BIT_SBD] && !sbd_q) begin
               sbd_n = 1'b1;
               rs_n  = 1'b1;
            end
            if (unmasked && !once_q) begin
               once_n = 1'b1;
               if (wr_data[RATE_W-1:0] != '0) begin
                  rate_n = wr_data[RATE_W-1:0];
                  rs_n   = 1'b1;
               end
               if (wr_data[BIT_WIN]) begin
                  win_n = 1'b1;
                  rs_n  = 1'b1;
               end
            end
         end
      end
      if (load_en) begin
         win_n  = load_data[BIT_WIN];
         rate_n = load_data[RATE_W-1:0];
         if (load_data[RATE_W-1:0] != '0) rs_n = 1'b1;
      end
      if (clk_sel != sel_q) rs_n = 1'b1;
      if (osc_q && !osc_up && clk_sel == 2'b01) rs_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q     <= 1'b0;
         sbd_q     <= 1'b0;
         rate_q    <= '0;
         once_q    <= 1'b0;
         restart_q <= 1'b0;
         sel_q     <= 2'b00;
         osc_q     <= 1'b0;
      end else begin
         win_q     <= win_n;
         sbd_q     <= sbd_n;
         rate_q    <= rate_n;
         once_q    <= once_n;
         restart_q <= rs_n;
         sel_q     <= clk_sel;
         osc_q     <= osc_up;
      end
   end

   p_write_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && once_q && !load_en) |=> ($stable(rate_q) && $stable(win_q)));
   p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[BIT_MASK] && !load_en) |=> $stable(rate_q));
   p_sbd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!special_mode && sbd_q) |=> sbd_q);
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick (
   input  logic [1:0] clk_sel,
   input  logic       aux_en,
   input  logic       irc_en,
   input  logic       osc_en,
   input  logic       stop_mode,
   input  logic       pseudo_stop,
   input  logic       osc_en_stop,
   output logic       tick
);
   logic src_en, keep_running;

   always_comb begin
      if (clk_sel[1])      src_en = aux_en;
      else if (clk_sel[0]) src_en = osc_en;
      else                 src_en = irc_en;
      keep_running = clk_sel[1] | (pseudo_stop & (clk_sel == 2'b01) & osc_en_stop);
      tick = src_en & (!stop_mode | keep_running);
   end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
   import wdog_pkg::*;
#(
   parameter int EXP_REDUCE = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate,
   output logic              reset_req
);
   localparam int CNT_W  = MAX_EXP - EXP_REDUCE;
   localparam int NCODES = 1 << RATE_W;

   logic [CNT_W-1:0] reload_tab [NCODES];
   logic [CNT_W-1:0] cnt_q;

   if (EXP_REDUCE < 0 || EXP_REDUCE > 13) begin : g_bad_reduce
      $error("EXP_REDUCE must lie in 0..13");
   end

   for (genvar g = 0; g < NCODES; g++) begin : g_tab
      if (g == 0) begin : g_off
         assign reload_tab[g] = '0;
      end else begin : g_on
         localparam int E = rate_exp(RATE_W'(g)) - EXP_REDUCE;
         assign reload_tab[g] = CNT_W'((64'd1 << E) - 64'd1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         reset_req <= 1'b0;
      end else begin
         reset_req <= 1'b0;
         if (restart) begin
            cnt_q <= reload_tab[rate];
         end else if (tick && rate != '0) begin
            if (cnt_q == '0) begin
               reset_req <= 1'b1;
               cnt_q     <= reload_tab[rate];
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rate == '0) |=> !reset_req);
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl
   import wdog_pkg::*;
#(
   parameter int EXP_REDUCE = 0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       special_mode,
   input  logic       stop_mode,
   input  logic       pseudo_stop,
   input  logic       osc_en_stop,
   input  logic       osc_up,
   input  logic [1:0] clk_sel,
   input  logic       aux_en,
   input  logic       irc_en,
   input  logic       osc_en,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       load_en,
   input  logic [7:0] load_data,
   output logic [7:0] rd_data,
   output logic       reset_req
);
   logic              win_q, sbd_q, restart_q, tick;
   logic [RATE_W-1:0] rate_q;

   wdog_ctrl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
      .wr_en(wr_en), .wr_data(wr_data), .load_en(load_en), .load_data(load_data),
      .clk_sel(clk_sel), .osc_up(osc_up),
      .win_q(win_q), .sbd_q(sbd_q), .rate_q(rate_q), .restart_q(restart_q)
   );

   wdog_tick u_tick (
      .clk_sel(clk_sel), .aux_en(aux_en), .irc_en(irc_en), .osc_en(osc_en),
      .stop_mode(stop_mode), .pseudo_stop(pseudo_stop), .osc_en_stop(osc_en_stop),
      .tick(tick)
   );

   wdog_count #(.EXP_REDUCE(EXP_REDUCE)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart_q),
      .rate(rate_q), .reset_req(reset_req)
   );

   assign rd_data = {win_q, sbd_q, 1'b0, 2'b00, rate_q};
endmodule

// File: tb/tb_wdog_ctl.sv
`timescale 1ns/1ps
module tb_wdog_ctl;
   localparam int RED = 10;
   localparam int P1  = 16;
   localparam int P2  = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic special_mode = 0, stop_mode = 0, pseudo_stop = 0, osc_en_stop = 0, osc_up = 1;
   logic [1:0] clk_sel = 2'b00;
   logic aux_en = 1, irc_en = 1, osc_en = 1;
   logic wr_en = 0, load_en = 0;
   logic [7:0] wr_data = '0, load_data = '0;
   logic [7:0] rd_data;
   logic reset_req;
   int checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;

   wdog_ctl #(.EXP_REDUCE(RED)) dut (
      .clk(clk), .rst_n(rst_n), .special_mode(special_mode), .stop_mode(stop_mode),
      .pseudo_stop(pseudo_stop), .osc_en_stop(osc_en_stop), .osc_up(osc_up),
      .clk_sel(clk_sel), .aux_en(aux_en), .irc_en(irc_en), .osc_en(osc_en),
      .wr_en(wr_en), .wr_data(wr_data), .load_en(load_en), .load_data(load_data),
      .rd_data(rd_data), .reset_req(reset_req)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; wr_en = 0; load_en = 0; special_mode = 0; stop_mode = 0;
      pseudo_stop = 0; osc_en_stop = 0; osc_up = 1; clk_sel = 2'b00;
      aux_en = 1; irc_en = 1; osc_en = 1;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1; wr_data = d;
      @(posedge clk); #1 wr_en = 0;
   endtask

   task automatic ld(input logic [7:0] d);
      @(negedge clk); load_en = 1; load_data = d;
      @(posedge clk); #1 load_en = 0;
   endtask

   task automatic set_sel(input logic [1:0] s);
      @(negedge clk); clk_sel = s;
      @(posedge clk); #1;
   endtask

   task automatic measure(output int n);
      n = 0;
      for (int i = 1; i <= 2000; i++) begin
         @(posedge clk); @(negedge clk);
         if (reset_req) begin n = i; return; end
      end
      n = -1;
   endtask

   task automatic idle(input int cycles, output bit seen);
      seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (reset_req) seen = 1;
      end
   endtask

   task automatic rdchk(input logic [7:0] exp, input string req);
      @(negedge clk);
      check(rd_data === exp, req, rd_data, exp);
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      check(rd_data === 8'h00, "R1 reset read", rd_data, 0);
      check(reset_req === 1'b0, "R1 reset request", reset_req, 0);
   endtask

   task automatic t_load();
      int n;
      do_reset();
      ld(8'h01);
      measure(n);
      check(n == P1 + 1, "R5 load starts timeout", n, P1 + 1);
      check(rd_data === 8'h01, "R5 load value", rd_data, 8'h01);
      @(negedge clk);
      check(reset_req === 1'b0, "R3 one-cycle pulse", reset_req, 0);
      measure(n);
      check(n == P1 - 1, "R3 reload period", n, P1 - 1);
   endtask

   task automatic t_write_once();
      int n;
      do_reset();
      wr(8'h02);
      measure(n);
      check(n == P2 + 1, "R2 code 2 period", n, P2 + 1);
      rdchk(8'h02, "R6 first write taken");
      wr(8'h03);
      rdchk(8'h02, "R6 second rate write ignored");
      wr(8'h80);
      rdchk(8'h02, "R6 window write ignored");
   endtask

   task automatic t_mask();
      int n;
      do_reset();
      wr(8'h23);
      rdchk(8'h00, "R7 masked write no effect");
      wr(8'h01);
      rdchk(8'h01, "R7 masked write did not use up once");
      measure(n);
      check(n == P1 + 0 || n == P1 + 1, "R2 code 1 period", n, P1 + 1);
   endtask

   task automatic t_zero();
      bit seen;
      do_reset();
      wr(8'h00);
      rdchk(8'h00, "R8 zero write");
      wr(8'h81);
      rdchk(8'h00, "R8 zero write used up once");
      idle(400, seen);
      check(!seen, "R4 code 000 no request", seen, 0);
   endtask

   task automatic t_sbd();
      int n;
      do_reset();
      ld(8'h01);
      repeat (8) @(negedge clk);
      wr(8'h40);
      measure(n);
      check(n == P1 + 1, "R9 set restarts", n, P1 + 1);
      rdchk(8'h41, "R9 bit set");
      wr(8'h00);
      rdchk(8'h41, "R9 bit cannot clear in normal mode");
      special_mode = 1;
      wr(8'h01);
      rdchk(8'h01, "R9 bit clears in special mode");
      special_mode = 0;
   endtask

   task automatic t_special();
      int n;
      do_reset();
      special_mode = 1;
      wr(8'h02);
      rdchk(8'h02, "R10 special write");
      wr(8'h81);
      rdchk(8'h81, "R10 special rewrite");
      repeat (8) @(negedge clk);
      wr(8'h23);
      measure(n);
      check(n == P1 + 1, "R10 masked write restarts", n, P1 + 1);
      check(rd_data === 8'h81, "R10 masked write keeps value", rd_data, 8'h81);
      special_mode = 0;
   endtask

   task automatic t_sel();
      int n;
      bit seen;
      do_reset();
      ld(8'h01);
      repeat (10) @(negedge clk);
      set_sel(2'b10);
      measure(n);
      check(n == P1 + 1, "R11 select change restarts", n, P1 + 1);
      set_sel(2'b01);
      repeat (8) @(negedge clk);
      osc_up = 0;
      @(posedge clk); #1;
      measure(n);
      check(n == P1 + 1, "R11 oscillator loss restarts", n, P1 + 1);
      osc_up = 1;
      osc_en = 0;
      idle(100, seen);
      check(!seen, "R11 unselected enables do not count", seen, 0);
      osc_en = 1;
   endtask

   task automatic t_stop();
      int n;
      bit seen;
      do_reset();
      stop_mode = 1;
      ld(8'h01);
      idle(100, seen);
      check(!seen, "R12 counter holds in stop", seen, 0);
      @(negedge clk);
      stop_mode = 0;
      measure(n);
      check(n == P1, "R12 resumes from held value", n, P1);
      stop_mode = 1;
      set_sel(2'b10);
      measure(n);
      check(n == P1 + 1, "R12 aux source runs in stop", n, P1 + 1);
      pseudo_stop = 1; osc_en_stop = 1;
      set_sel(2'b01);
      measure(n);
      check(n == P1 + 1, "R12 pseudo stop with oscillator runs", n, P1 + 1);
      osc_en_stop = 0;
      idle(100, seen);
      check(!seen, "R12 pseudo stop without oscillator holds", seen, 0);
      stop_mode = 0; pseudo_stop = 0;
   endtask

   initial begin
      t_reset();
      t_load();
      t_write_once();
      t_mask();
      t_zero();
      t_sbd();
      t_special();
      t_sel();
      t_stop();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule